// File: doc/BRIEF.md
# Shared External Bus Fetch Sequencer

This block arbitrates the external bus for an instruction that needs three memory words at once: the instruction word itself, a data word from program memory and a data word from data memory. Each of the three fetches comes with a flag. The flag says whether that fetch must go off-chip. Fetches that stay on-chip complete in the base cycle and never need the bus. Off-chip fetches share one external bus, so they must be served one after another.

When a start strobe arrives, the sequencer captures the three flags. It then grants the bus to the off-chip fetches one at a time, in a fixed order. While more bus work is still pending it holds the core in stall. In the cycle the last word arrives it raises a one-cycle done pulse. The external device can stretch any bus access by holding its ready input low. Each low sample adds one cycle to the access currently on the bus.

Top module: `xfetch_seq`

## Requirements
- R1: After reset, and before any start is accepted, o_bus_req, o_owner, o_stall and o_done are all 0.
- R2: Flag bits are i_offchip[0] for the instruction word, i_offchip[1] for the program-memory data word and i_offchip[2] for the data-memory data word. When at most one flag is set and ready is high, o_done is 1 in the cycle after the start edge and o_stall stays 0.
- R3: When exactly two flags are set and ready stays high, the sequence lasts two cycles: one stall cycle, then one done cycle.
- R4: When all three flags are set and ready stays high, the sequence lasts three cycles: two stall cycles, then one done cycle.
- R5: The owner code on o_owner is 0 for idle, 1 for the instruction word, 2 for the program-memory data word and 3 for the data-memory data word. Off-chip fetches take the bus in the order instruction, then program-memory data, then data-memory data.
- R6: Each cycle in which a fetch holds the bus and i_ext_rdy is low, that fetch keeps the bus for one more cycle. Stall stays high during every such extra cycle.
- R7: A start strobe that arrives while a sequence is in progress has no effect. The owner order, the stall count and the done timing stay those of the original flags.
- R8: o_done is a single-cycle pulse, and o_stall is never high in the same cycle as o_done.
- R9: o_bus_req is 1 exactly when o_owner is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Begin a fetch sequence (taken only when idle) |
| i_offchip | input | 3 | Off-chip flag per fetch: bit0 instruction, bit1 PM data, bit2 DM data |
| i_ext_rdy | input | 1 | External bus ready; low stretches the current access |
| o_bus_req | output | 1 | External bus request |
| o_owner | output | 2 | Fetch that owns the bus (0 idle, 1 instr, 2 PM data, 3 DM data) |
| o_stall | output | 1 | Overhead cycle: core must hold |
| o_done | output | 1 | All three words available this cycle |

## Verification
The bench builds the block with the default fetch count of three. This makes every off-chip count from zero to three reachable, and so gives sequences with no overhead, one overhead cycle and two overhead cycles. Ready-low patterns are applied to the first access and to a middle access. A start that is re-asserted during a sequence tests that the captured flags cannot be disturbed.

// File: rtl/xfetch_pkg.sv
package xfetch_pkg;
    localparam int N_FETCH = 3;
    localparam int OWN_W   = $clog2(N_FETCH + 1);

    typedef logic [OWN_W-1:0]   owner_t;
    typedef logic [N_FETCH-1:0] fmask_t;

    localparam owner_t OWN_IDLE = '0;

    typedef struct packed {
        logic   active;
        owner_t cur;
        fmask_t pend;
    } seq_state_t;

    function automatic logic any_set(input fmask_t m);
        return |m;
    endfunction
endpackage

// File: rtl/xfetch_pick.sv
module xfetch_pick
    import xfetch_pkg::*;
#(
    parameter int N  = N_FETCH,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  i_req,
    output logic          o_found,
    output logic [CW-1:0] o_code,
    output logic [N-1:0]  o_rest
);
    always_comb begin
        o_found = 1'b0;
        o_code  = '0;
        o_rest  = i_req;
        for (int i = N - 1; i >= 0; i--) begin
            if (i_req[i]) begin
                o_found = 1'b1;
                o_code  = CW'(i + 1);
                o_rest  = i_req;
                o_rest[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/xfetch_fsm.sv
module xfetch_fsm
    import xfetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       i_start,
    input  fmask_t     i_flags,
    input  logic       i_rdy,
    output seq_state_t o_state,
    output logic       o_complete
);
    seq_state_t st;
    logic   first_found, next_found;
    owner_t first_code, next_code;
    fmask_t first_rest, next_rest;

    xfetch_pick #(.N(N_FETCH), .CW(OWN_W)) u_first (
        .i_req(i_flags), .o_found(first_found), .o_code(first_code), .o_rest(first_rest)
    );

    xfetch_pick #(.N(N_FETCH), .CW(OWN_W)) u_next (
        .i_req(st.pend), .o_found(next_found), .o_code(next_code), .o_rest(next_rest)
    );

    assign o_complete = st.active && ((st.cur == OWN_IDLE) || i_rdy);
    assign o_state    = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!st.active) begin
            if (i_start) begin
                st.active <= 1'b1;
                st.cur    <= first_found ? first_code : OWN_IDLE;
                st.pend   <= first_rest;
            end
        end else if (o_complete) begin
            if (next_found) begin
                st.cur  <= next_code;
                st.pend <= next_rest;
            end else begin
                st <= '0;
            end
        end
    end
endmodule

// File: rtl/xfetch_seq.sv
module xfetch_seq
    import xfetch_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               i_start,
    input  logic [N_FETCH-1:0] i_offchip,
    input  logic               i_ext_rdy,
    output logic               o_bus_req,
    output logic [OWN_W-1:0]   o_owner,
    output logic               o_stall,
    output logic               o_done
);
    seq_state_t st;
    logic       complete;

    xfetch_fsm u_fsm (
        .clk(clk), .rst(rst), .i_start(i_start), .i_flags(i_offchip),
        .i_rdy(i_ext_rdy), .o_state(st), .o_complete(complete)
    );

    always_comb begin
        o_done    = complete && !any_set(st.pend);
        o_stall   = st.active && !o_done;
        o_owner   = st.active ? st.cur : OWN_IDLE;
        o_bus_req = st.active && (st.cur != OWN_IDLE);
    end
endmodule

// File: rtl/xfetch_seq_chk.sv
module xfetch_seq_chk
    import xfetch_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               i_ext_rdy,
    input logic               o_bus_req,
    input logic [OWN_W-1:0]   o_owner,
    input logic               o_stall,
    input logic               o_done
);
    AST_REQ_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        o_bus_req |-> (o_owner != '0)); // R9
    AST_OWNER_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (o_owner != '0) |-> o_bus_req); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        o_done |=> !o_done); // R8
    AST_NO_STALL_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !(o_stall && o_done)); // R8
    AST_STALL_RUNS_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        o_stall |=> (o_stall || o_done)); // R3
    AST_OWNER_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((o_owner != '0) && ($past(o_owner) != '0) && (o_owner != $past(o_owner)))
        |-> (o_owner > $past(o_owner))); // R5
    AST_WAIT_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst)
        (o_bus_req && !i_ext_rdy) |=> (o_bus_req && (o_owner == $past(o_owner)))); // R6
endmodule

bind xfetch_seq xfetch_seq_chk u_chk (
    .clk(clk), .rst(rst), .i_ext_rdy(i_ext_rdy), .o_bus_req(o_bus_req),
    .o_owner(o_owner), .o_stall(o_stall), .o_done(o_done)
);

// File: tb/xfetch_seq_bench.sv
module xfetch_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] offc = 3'b000;
    logic       rdy = 1'b1;
    logic       bus_req, stall, done;
    logic [1:0] owner;

    int n_chk = 0;
    int n_fail = 0;
    int stall_seen = 0;
    int done_seen = 0;
    bit finished = 0;
    int q[$];

    always #2.5 clk = ~clk;

    xfetch_seq u_xfetch_seq (
        .clk(clk), .rst(rst), .i_start(start), .i_offchip(offc), .i_ext_rdy(rdy),
        .o_bus_req(bus_req), .o_owner(owner), .o_stall(stall), .o_done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic [2:0] fl, input logic r, input string tag);
        int  e_own;
        bit  e_done, e_stall, e_req;
        @(negedge clk);
        start = st; offc = fl; rdy = r;
        #1;
        if (q.size() == 0) begin
            e_own = 0; e_done = 0; e_stall = 0; e_req = 0;
        end else begin
            e_own   = q[0];
            e_req   = (q[0] != 0);
            e_done  = (q.size() == 1) && (q[0] == 0 || r);
            e_stall = !e_done;
        end
        chk(owner == e_own, tag, "owner R5", owner, e_own);
        chk(bus_req == e_req, tag, "bus_req R9", bus_req, e_req);
        chk(done == e_done, tag, "done R8", done, e_done);
        chk(stall == e_stall, tag, "stall R6", stall, e_stall);
        if (stall) stall_seen++;
        if (done) done_seen++;
        @(posedge clk);
        if (!rst) begin
            if (q.size() != 0) begin
                if (q[0] == 0 || r) void'(q.pop_front());
            end else if (st) begin
                for (int i = 0; i < 3; i++) if (fl[i]) q.push_back(i + 1);
                if (q.size() == 0) q.push_back(0);
            end
        end
    endtask

    // lowcyc: number of leading bus cycles of the access with code lowown held not-ready
    task automatic run_seq(input logic [2:0] fl, input int lowown, input int lowcyc,
                           input bit poke, input int exp_stalls, input string tag);
        int left = lowcyc;
        int guard = 0;
        stall_seen = 0; done_seen = 0;
        step(1'b1, fl, 1'b1, tag);
        while (q.size() != 0 && guard < 50) begin
            logic r = 1'b1;
            if (q[0] == lowown && left > 0) begin r = 1'b0; left--; end
            step(poke, poke ? ~fl : fl, r, tag);
            guard++;
        end
        chk(stall_seen == exp_stalls, tag, "stall count", stall_seen, exp_stalls);
        chk(done_seen == 1, tag, "done pulses", done_seen, 1);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 3'b000, 1'b1, "R1");
        rst = 1'b0;
        step(1'b0, 3'b111, 1'b1, "R1 idle");
        run_seq(3'b000, 0, 0, 0, 0, "R2 none");
        run_seq(3'b001, 0, 0, 0, 0, "R2 instr");
        run_seq(3'b010, 0, 0, 0, 0, "R2 pm");
        run_seq(3'b100, 0, 0, 0, 0, "R2 dm");
        run_seq(3'b011, 0, 0, 0, 1, "R3 i+pm");
        run_seq(3'b110, 0, 0, 0, 1, "R3 R5 pm+dm");
        run_seq(3'b101, 0, 0, 0, 1, "R3 i+dm");
        run_seq(3'b111, 0, 0, 0, 2, "R4 R5 all");
        run_seq(3'b111, 2, 2, 0, 4, "R6 mid wait");
        run_seq(3'b001, 1, 3, 0, 3, "R6 single wait");
        run_seq(3'b110, 3, 1, 0, 2, "R6 last wait");
        run_seq(3'b010, 0, 0, 1, 0, "R7 poke single");
        run_seq(3'b101, 0, 0, 1, 1, "R7 poke pair");
        run_seq(3'b111, 1, 1, 1, 3, "R7 R8 poke all");
        step(1'b0, 3'b000, 1'b1, "R1 end idle");
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule